// File: doc/BRIEF.md
# Microprogram Sequencer with Dispatch Tables

This block is the control unit of a small multi-cycle processor. It is built as a microcoded engine. A 4-bit micro-address register selects one 19-bit word from an internal constant control store. The fields of that word are decoded into the individual strobes and selects that steer the datapath: ALU operation, ALU operand sources, register-file write controls, memory access, instruction-register load, and program-counter update. The datapath and the memory sit outside the block.

Every word carries a 2-bit sequencing field, and that field chooses the next micro-address from one of four sources:

- address zero, which is the start of the fetch routine;
- the incremented current address;
- one of two opcode-indexed dispatch tables.

The first table branches out of the decode word into the routine for each instruction class. The second table splits the shared load/store address step, and it also joins the two exception entry words to the common exception tail. That tail captures the return address into the exception program counter and then forces the PC to the handler vector.

An arithmetic overflow reported while the R-type finish word is active diverts the sequencer into the overflow entry word instead of returning to fetch. The result write of that word still happens. Any opcode the first table does not list lands on the undefined-instruction entry word.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the micro-address `upc` becomes 0 after that edge.
- R2: A word whose sequencing field is 11 is followed by the word at its own address plus one, so fetch (0) is always followed by decode (1).
- R3: From decode, dispatch table 1 selects the next word by opcode: 000000 goes to 6, 000010 to 9, 000100 to 8, 001011 to 10, and both 100011 and 101011 go to 2.
- R4: From decode, any opcode not listed in R3 goes to word 12.
- R5: Dispatch table 2 sends 100011 to 3, 101011 to 5, and every other opcode to 14. It is used by words 2, 12 and 13.
- R6: Words 4, 5, 8, 9, 11 and 15 use sequencing field 00 and are followed by word 0.
- R7: When `overflow` is high during word 7, the next word is 13 instead of 0. `overflow` has no effect on the sequence at any other word.
- R8: The fetch word (0) drives the following outputs:
  - `mem_read`=1, `mem_write`=0, `iord`=0;
  - `ir_write`=1;
  - `pc_write`=1, `pc_src`=00;
  - `alu_op`=00 (add), `alu_src_a`=0 (PC), `alu_src_b`=001 (constant 4).
  
  `mem_read` and `mem_write` are never high together.
- R9: The exception words drive these outputs:
  - Word 12 drives `cause_write`=1 with `cause_val`=0.
  - Word 13 drives `cause_write`=1 with `cause_val`=1.
  - Word 14 drives `epc_write`=1 with `alu_op`=01 (subtract), `alu_src_a`=0 and `alu_src_b`=001.
  - Word 15 drives `pc_write`=1 with `pc_src`=11 (exception vector).
- R10: Full traces of `upc`, one value per cycle, starting at fetch:
  - load: 0,1,2,3,4,0
  - store: 0,1,2,5,0
  - R-type: 0,1,6,7,0
  - branch: 0,1,8,0
  - jump: 0,1,9,0
  - or-immediate: 0,1,10,11,0
  - undefined opcode: 0,1,12,14,15,0
  - R-type with overflow: 0,1,6,7,13,14,15,0
- R11: The branch and jump words drive these outputs:
  - Decode word (1): `target_write`=1 and `alu_src_b`=011.
  - Branch word (8): `pc_write_cond`=1, `pc_src`=01 and `alu_op`=01.
  - Jump word (9): `pc_write`=1 and `pc_src`=10.
- R12: The write-back and store words drive these outputs:
  - Load write-back word (4): `reg_write`=1 and `mem_to_reg`=1.
  - Store word (5): `mem_write`=1 and `iord`=1.
  - R-type finish word (7): `reg_write`=1, `reg_dst`=1 and `alu_op`=10.
  - Or-immediate words (10, 11): `alu_op`=11 and `alu_src_b`=100.
  
  All outputs are combinational from the current `upc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| overflow | input | 1 | ALU overflow flag |
| upc | output | 4 | Current micro-address |
| alu_op | output | 2 | ALU operation: 00 add, 01 sub, 10 function code, 11 OR |
| alu_src_a | output | 1 | ALU A operand: 0 PC, 1 register rs |
| alu_src_b | output | 3 | ALU B operand: 000 rt, 001 four, 010 sign-ext, 011 sign-ext shifted 2, 100 zero-ext |
| reg_write | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Register write data taken from memory |
| reg_dst | output | 1 | Register destination is rd (else rt) |
| target_write | output | 1 | Branch target register load |
| epc_write | output | 1 | Exception program counter load |
| cause_write | output | 1 | Cause register load |
| cause_val | output | 1 | Cause value: 0 undefined instruction, 1 overflow |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| iord | output | 1 | Memory address from ALU output (else PC) |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC load |
| pc_write_cond | output | 1 | PC load when the ALU result is zero |
| pc_src | output | 2 | PC source: 00 ALU, 01 target, 10 jump address, 11 exception vector |

## Verification
The bench pays most attention to the fallback of table 1. An unlisted opcode that matched a real entry, or that fell through to word 0, would skip the cause write and show up as a wrong word after decode. Table 2 is exercised with a non-memory opcode as well. A design that sent that opcode to word 0 would lose the exception tail, and one that mixed up the load and store slots would swap words 3 and 5.

Overflow is held high across whole load and R-type executions. This catches a design that samples the flag at the wrong word, and one that reacts to it anywhere other than the R-type finish step. Every word of each trace is also checked against the control values it must drive, so a field packed into the wrong bit positions shows up as a wrong strobe.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int OP_W    = 6;
    localparam int UA_W    = 4;
    localparam int UWORD_W = 19;

    // Overflow diversion point and destination
    localparam logic [UA_W-1:0] OVF_CHECK_UA = 4'd7;
    localparam logic [UA_W-1:0] OVF_TRAP_UA  = 4'd13;
    localparam logic [UA_W-1:0] UNDEF_UA     = 4'd12;
    localparam logic [UA_W-1:0] EXC_TAIL_UA  = 4'd14;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'b001011;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

    typedef enum logic [1:0] {
        SEQ_ZERO  = 2'b00,
        SEQ_DISP1 = 2'b01,
        SEQ_DISP2 = 2'b10,
        SEQ_INCR  = 2'b11
    } seq_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_OR   = 2'b11
    } alu_e;

    typedef enum logic [2:0] {
        BSEL_RT      = 3'b000,
        BSEL_FOUR    = 3'b001,
        BSEL_SEXT    = 3'b010,
        BSEL_SEXT_S2 = 3'b011,
        BSEL_ZEXT    = 3'b100
    } bsel_e;

    typedef enum logic [3:0] {
        DST_NONE        = 4'd0,
        DST_TARGET      = 4'd1,
        DST_RD_ALU      = 4'd2,
        DST_RT_MEM      = 4'd3,
        DST_RT_ALU      = 4'd4,
        DST_EPC         = 4'd5,
        DST_CAUSE_UNDEF = 4'd6,
        DST_CAUSE_OVF   = 4'd7
    } dst_e;

    typedef enum logic [2:0] {
        MEM_IDLE   = 3'd0,
        MEM_RD_PC  = 3'd1,
        MEM_RD_ALU = 3'd2,
        MEM_WR_ALU = 3'd3
    } mem_e;

    typedef enum logic [2:0] {
        PCW_HOLD   = 3'd0,
        PCW_ALU    = 3'd1,
        PCW_BRANCH = 3'd2,
        PCW_JUMP   = 3'd3,
        PCW_VECTOR = 3'd4
    } pcw_e;

    typedef struct packed {
        alu_e  alu;
        logic  src_a;
        bsel_e src_b;
        dst_e  dst;
        mem_e  mem;
        logic  ir_load;
        pcw_e  pcw;
        seq_e  seq;
    } uword_t;

    typedef struct packed {
        logic [1:0] alu_op;
        logic       alu_src_a;
        logic [2:0] alu_src_b;
        logic       reg_write;
        logic       mem_to_reg;
        logic       reg_dst;
        logic       target_write;
        logic       epc_write;
        logic       cause_write;
        logic       cause_val;
        logic       mem_read;
        logic       mem_write;
        logic       iord;
        logic       ir_write;
        logic       pc_write;
        logic       pc_write_cond;
        logic [1:0] pc_src;
    } ctrl_t;

    function automatic uword_t mk(alu_e a, logic sa, bsel_e sb, dst_e d,
                                  mem_e m, logic ir, pcw_e p, seq_e s);
        uword_t w;
        w.alu = a; w.src_a = sa; w.src_b = sb; w.dst = d;
        w.mem = m; w.ir_load = ir; w.pcw = p; w.seq = s;
        return w;
    endfunction

    // Control store contents, one word per micro-address
    function automatic uword_t ustore_word(logic [UA_W-1:0] a);
        case (a)
            4'd0:  return mk(ALU_ADD,  1'b0, BSEL_FOUR,    DST_NONE,        MEM_RD_PC,  1'b1, PCW_ALU,    SEQ_INCR);
            4'd1:  return mk(ALU_ADD,  1'b0, BSEL_SEXT_S2, DST_TARGET,      MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_DISP1);
            4'd2:  return mk(ALU_ADD,  1'b1, BSEL_SEXT,    DST_NONE,        MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_DISP2);
            4'd3:  return mk(ALU_ADD,  1'b1, BSEL_SEXT,    DST_NONE,        MEM_RD_ALU, 1'b0, PCW_HOLD,   SEQ_INCR);
            4'd4:  return mk(ALU_ADD,  1'b1, BSEL_SEXT,    DST_RT_MEM,      MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_ZERO);
            4'd5:  return mk(ALU_ADD,  1'b1, BSEL_SEXT,    DST_NONE,        MEM_WR_ALU, 1'b0, PCW_HOLD,   SEQ_ZERO);
            4'd6:  return mk(ALU_FUNC, 1'b1, BSEL_RT,      DST_NONE,        MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_INCR);
            4'd7:  return mk(ALU_FUNC, 1'b1, BSEL_RT,      DST_RD_ALU,      MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_ZERO);
            4'd8:  return mk(ALU_SUB,  1'b1, BSEL_RT,      DST_NONE,        MEM_IDLE,   1'b0, PCW_BRANCH, SEQ_ZERO);
            4'd9:  return mk(ALU_ADD,  1'b0, BSEL_RT,      DST_NONE,        MEM_IDLE,   1'b0, PCW_JUMP,   SEQ_ZERO);
            4'd10: return mk(ALU_OR,   1'b1, BSEL_ZEXT,    DST_NONE,        MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_INCR);
            4'd11: return mk(ALU_OR,   1'b1, BSEL_ZEXT,    DST_RT_ALU,      MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_ZERO);
            4'd12: return mk(ALU_ADD,  1'b0, BSEL_RT,      DST_CAUSE_UNDEF, MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_DISP2);
            4'd13: return mk(ALU_ADD,  1'b0, BSEL_RT,      DST_CAUSE_OVF,   MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_DISP2);
            4'd14: return mk(ALU_SUB,  1'b0, BSEL_FOUR,    DST_EPC,         MEM_IDLE,   1'b0, PCW_HOLD,   SEQ_INCR);
            default: return mk(ALU_ADD, 1'b0, BSEL_RT,     DST_NONE,        MEM_IDLE,   1'b0, PCW_VECTOR, SEQ_ZERO);
        endcase
    endfunction

    // First dispatch: class routine entry, unknown opcodes trap
    function automatic logic [UA_W-1:0] dispatch_primary(logic [OP_W-1:0] op);
        case (op)
            OPC_RTYPE: return 4'd6;
            OPC_JUMP:  return 4'd9;
            OPC_BEQ:   return 4'd8;
            OPC_ORI:   return 4'd10;
            OPC_LOAD,
            OPC_STORE: return 4'd2;
            default:   return UNDEF_UA;
        endcase
    endfunction

    // Second dispatch: load/store split, everything else joins the exception tail
    function automatic logic [UA_W-1:0] dispatch_secondary(logic [OP_W-1:0] op);
        case (op)
            OPC_LOAD:  return 4'd3;
            OPC_STORE: return 4'd5;
            default:   return EXC_TAIL_UA;
        endcase
    endfunction

endpackage

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
    import ucode_pkg::*;
#(
    parameter int OPW       = OP_W,
    parameter int UAW       = UA_W,
    parameter int TABLE_SEL = 1
) (
    input  logic [OPW-1:0] op,
    output logic [UAW-1:0] target
);
    generate
        if (TABLE_SEL == 1) begin : g_primary
            assign target = dispatch_primary(op);
        end else begin : g_secondary
            assign target = dispatch_secondary(op);
        end
    endgenerate
endmodule

// File: rtl/ucode_store.sv
module ucode_store
    import ucode_pkg::*;
#(
    parameter int UAW = UA_W
) (
    input  logic [UAW-1:0] addr,
    output uword_t         word
);
    localparam int DEPTH = 1 << UAW;

    uword_t rom [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            assign rom[g] = ustore_word(UAW'(g));
        end
    endgenerate

    assign word = rom[addr];
endmodule

// File: rtl/ucode_decode.sv
module ucode_decode
    import ucode_pkg::*;
(
    input  uword_t w,
    output ctrl_t  c
);
    always_comb begin
        c               = '0;
        c.alu_op        = w.alu;
        c.alu_src_a     = w.src_a;
        c.alu_src_b     = w.src_b;

        c.reg_write     = (w.dst == DST_RD_ALU) || (w.dst == DST_RT_MEM) || (w.dst == DST_RT_ALU);
        c.mem_to_reg    = (w.dst == DST_RT_MEM);
        c.reg_dst       = (w.dst == DST_RD_ALU);
        c.target_write  = (w.dst == DST_TARGET);
        c.epc_write     = (w.dst == DST_EPC);
        c.cause_write   = (w.dst == DST_CAUSE_UNDEF) || (w.dst == DST_CAUSE_OVF);
        c.cause_val     = (w.dst == DST_CAUSE_OVF);

        c.mem_read      = (w.mem == MEM_RD_PC) || (w.mem == MEM_RD_ALU);
        c.mem_write     = (w.mem == MEM_WR_ALU);
        c.iord          = (w.mem == MEM_RD_ALU) || (w.mem == MEM_WR_ALU);
        c.ir_write      = w.ir_load;

        c.pc_write      = (w.pcw == PCW_ALU) || (w.pcw == PCW_JUMP) || (w.pcw == PCW_VECTOR);
        c.pc_write_cond = (w.pcw == PCW_BRANCH);
        case (w.pcw)
            PCW_BRANCH: c.pc_src = 2'b01;
            PCW_JUMP:   c.pc_src = 2'b10;
            PCW_VECTOR: c.pc_src = 2'b11;
            default:    c.pc_src = 2'b00;
        endcase
    end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import ucode_pkg::*;
#(
    parameter int OPW = OP_W,
    parameter int UAW = UA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    input  logic           overflow,
    output logic [UAW-1:0] upc,
    output logic [1:0]     alu_op,
    output logic           alu_src_a,
    output logic [2:0]     alu_src_b,
    output logic           reg_write,
    output logic           mem_to_reg,
    output logic           reg_dst,
    output logic           target_write,
    output logic           epc_write,
    output logic           cause_write,
    output logic           cause_val,
    output logic           mem_read,
    output logic           mem_write,
    output logic           iord,
    output logic           ir_write,
    output logic           pc_write,
    output logic           pc_write_cond,
    output logic [1:0]     pc_src
);
    logic [UAW-1:0] ua_q, ua_d, ua_inc, disp1_ua, disp2_ua, seq_pick;
    uword_t         word;
    ctrl_t          ctl;

    ucode_store #(.UAW(UAW)) u_store (
        .addr (ua_q),
        .word (word)
    );

    ucode_dispatch #(.OPW(OPW), .UAW(UAW), .TABLE_SEL(1)) u_disp1 (
        .op     (opcode),
        .target (disp1_ua)
    );

    ucode_dispatch #(.OPW(OPW), .UAW(UAW), .TABLE_SEL(2)) u_disp2 (
        .op     (opcode),
        .target (disp2_ua)
    );

    ucode_decode u_decode (
        .w (word),
        .c (ctl)
    );

    assign ua_inc = ua_q + UAW'(1);

    always_comb begin
        case (word.seq)
            SEQ_ZERO:  seq_pick = '0;
            SEQ_DISP1: seq_pick = disp1_ua;
            SEQ_DISP2: seq_pick = disp2_ua;
            default:   seq_pick = ua_inc;
        endcase
        ua_d = seq_pick;
        if (overflow && (ua_q == UAW'(OVF_CHECK_UA)))
            ua_d = UAW'(OVF_TRAP_UA);
    end

    always_ff @(posedge clk) begin
        if (rst) ua_q <= '0;
        else     ua_q <= ua_d;
    end

    assign upc           = ua_q;
    assign alu_op        = ctl.alu_op;
    assign alu_src_a     = ctl.alu_src_a;
    assign alu_src_b     = ctl.alu_src_b;
    assign reg_write     = ctl.reg_write;
    assign mem_to_reg    = ctl.mem_to_reg;
    assign reg_dst       = ctl.reg_dst;
    assign target_write  = ctl.target_write;
    assign epc_write     = ctl.epc_write;
    assign cause_write   = ctl.cause_write;
    assign cause_val     = ctl.cause_val;
    assign mem_read      = ctl.mem_read;
    assign mem_write     = ctl.mem_write;
    assign iord          = ctl.iord;
    assign ir_write      = ctl.ir_write;
    assign pc_write      = ctl.pc_write;
    assign pc_write_cond = ctl.pc_write_cond;
    assign pc_src        = ctl.pc_src;
endmodule

// File: rtl/ucode_sequencer_chk.sv
module ucode_sequencer_chk #(
    parameter int OPW = 6,
    parameter int UAW = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [OPW-1:0] opcode,
    input logic           overflow,
    input logic [UAW-1:0] upc,
    input logic           mem_read,
    input logic           mem_write
);
    logic known_op;
    assign known_op = (opcode == 6'b000000) || (opcode == 6'b000010) ||
                      (opcode == 6'b000100) || (opcode == 6'b001011) ||
                      (opcode == 6'b100011) || (opcode == 6'b101011);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (upc == '0)); // R1

    AST_FETCH_STEPS: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd0) |=> (upc == 4'd1)); // R2

    AST_UNKNOWN_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd1 && !known_op) |=> (upc == 4'd12)); // R4

    AST_LOAD_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd2 && opcode == 6'b100011) |=> (upc == 4'd3)); // R5

    AST_ROUTINE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd4 || upc == 4'd5 || upc == 4'd8 || upc == 4'd9 ||
         upc == 4'd11 || upc == 4'd15) |=> (upc == 4'd0)); // R6

    AST_OVF_DIVERTS: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd7 && overflow) |=> (upc == 4'd13)); // R7

    AST_EPC_THEN_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (upc == 4'd14) |=> (upc == 4'd15)); // R9

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write)); // R8
endmodule

bind ucode_sequencer ucode_sequencer_chk #(.OPW(OPW), .UAW(UAW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .overflow  (overflow),
    .upc       (upc),
    .mem_read  (mem_read),
    .mem_write (mem_write)
);

// File: tb/ucode_sequencer_tb.sv
module ucode_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic       overflow = 1'b0;
    logic [3:0] upc;
    logic [1:0] alu_op, pc_src;
    logic [2:0] alu_src_b;
    logic alu_src_a, reg_write, mem_to_reg, reg_dst, target_write, epc_write;
    logic cause_write, cause_val, mem_read, mem_write, iord, ir_write;
    logic pc_write, pc_write_cond;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ucode_sequencer u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .overflow(overflow), .upc(upc),
        .alu_op(alu_op), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
        .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
        .target_write(target_write), .epc_write(epc_write),
        .cause_write(cause_write), .cause_val(cause_val),
        .mem_read(mem_read), .mem_write(mem_write), .iord(iord),
        .ir_write(ir_write), .pc_write(pc_write),
        .pc_write_cond(pc_write_cond), .pc_src(pc_src)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference of the next word, written from R2..R7
    function automatic int ref_next(int ua, logic [5:0] op, logic ovf);
        case (ua)
            0: return 1;
            1: begin
                if (op == 6'b000000) return 6;
                if (op == 6'b000010) return 9;
                if (op == 6'b000100) return 8;
                if (op == 6'b001011) return 10;
                if (op == 6'b100011 || op == 6'b101011) return 2;
                return 12;
            end
            2, 12, 13: return (op == 6'b100011) ? 3 : (op == 6'b101011) ? 5 : 14;
            3: return 4;
            6: return 7;
            7: return ovf ? 13 : 0;
            10: return 11;
            14: return 15;
            default: return 0;
        endcase
    endfunction

    int  model_ua = 0;
    bit  model_on = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            model_ua <= 0;
            model_on <= 1'b1;
        end else if (model_on) begin
            model_ua <= ref_next(model_ua, opcode, overflow);
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst && !done)
            chk("R10", "per-cycle model upc", int'(upc), model_ua);
    end

    // Control values each word must drive (R8, R9, R11, R12)
    task automatic check_word();
        case (upc)
            4'd0: begin
                chk("R8", "fetch mem_read", mem_read, 1);
                chk("R8", "fetch mem_write", mem_write, 0);
                chk("R8", "fetch iord", iord, 0);
                chk("R8", "fetch ir_write", ir_write, 1);
                chk("R8", "fetch pc_write", pc_write, 1);
                chk("R8", "fetch pc_src", pc_src, 0);
                chk("R8", "fetch alu_op", alu_op, 0);
                chk("R8", "fetch src_a", alu_src_a, 0);
                chk("R8", "fetch src_b", alu_src_b, 1);
            end
            4'd1: begin
                chk("R11", "decode target_write", target_write, 1);
                chk("R11", "decode src_b", alu_src_b, 3);
            end
            4'd4: begin
                chk("R12", "lw wb reg_write", reg_write, 1);
                chk("R12", "lw wb mem_to_reg", mem_to_reg, 1);
            end
            4'd5: begin
                chk("R12", "sw mem_write", mem_write, 1);
                chk("R12", "sw iord", iord, 1);
            end
            4'd7: begin
                chk("R12", "rfin reg_write", reg_write, 1);
                chk("R12", "rfin reg_dst", reg_dst, 1);
                chk("R12", "rfin alu_op", alu_op, 2);
            end
            4'd8: begin
                chk("R11", "beq pc_write_cond", pc_write_cond, 1);
                chk("R11", "beq pc_src", pc_src, 1);
                chk("R11", "beq alu_op", alu_op, 1);
            end
            4'd9: begin
                chk("R11", "jmp pc_write", pc_write, 1);
                chk("R11", "jmp pc_src", pc_src, 2);
            end
            4'd10, 4'd11: begin
                chk("R12", "ori alu_op", alu_op, 3);
                chk("R12", "ori src_b", alu_src_b, 4);
            end
            4'd12: begin
                chk("R9", "undef cause_write", cause_write, 1);
                chk("R9", "undef cause_val", cause_val, 0);
            end
            4'd13: begin
                chk("R9", "ovf cause_write", cause_write, 1);
                chk("R9", "ovf cause_val", cause_val, 1);
            end
            4'd14: begin
                chk("R9", "epc epc_write", epc_write, 1);
                chk("R9", "epc alu_op", alu_op, 1);
                chk("R9", "epc src_a", alu_src_a, 0);
                chk("R9", "epc src_b", alu_src_b, 1);
            end
            4'd15: begin
                chk("R9", "vector pc_write", pc_write, 1);
                chk("R9", "vector pc_src", pc_src, 3);
            end
            default: ;
        endcase
        checks++;
        if (mem_read && mem_write) begin
            fails++;
            $display("FAIL R8 read/write overlap: actual 1 expected 0");
        end
    endtask

    // Called at a falling edge with upc at fetch; ends at fetch again
    task automatic run_trace(string req, logic [5:0] op, logic ovf, int exp[$]);
        opcode   = op;
        overflow = ovf;
        foreach (exp[k]) begin
            chk(req, "trace upc", int'(upc), exp[k]);
            check_word();
            if (k < exp.size() - 1) @(negedge clk);
        end
    endtask

    initial begin : wd
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset upc", int'(upc), 0);
        rst = 1'b0;

        run_trace("R2", 6'b100011, 1'b0, '{0, 1, 2, 3, 4, 0});          // load, R3 R5
        run_trace("R3", 6'b101011, 1'b0, '{0, 1, 2, 5, 0});             // store, R5
        run_trace("R10", 6'b000000, 1'b0, '{0, 1, 6, 7, 0});            // R-type
        run_trace("R6", 6'b000100, 1'b0, '{0, 1, 8, 0});                // branch
        run_trace("R6", 6'b000010, 1'b0, '{0, 1, 9, 0});                // jump
        run_trace("R3", 6'b001011, 1'b0, '{0, 1, 10, 11, 0});           // or-immediate
        run_trace("R4", 6'b111111, 1'b0, '{0, 1, 12, 14, 15, 0});       // unlisted
        run_trace("R4", 6'b000001, 1'b0, '{0, 1, 12, 14, 15, 0});       // near-miss opcode
        run_trace("R7", 6'b000000, 1'b1, '{0, 1, 6, 7, 13, 14, 15, 0}); // overflow trap
        run_trace("R7", 6'b100011, 1'b1, '{0, 1, 2, 3, 4, 0});          // overflow ignored
        run_trace("R7", 6'b001011, 1'b1, '{0, 1, 10, 11, 0});           // overflow ignored

        // Reset in the middle of a routine
        opcode   = 6'b000000;
        overflow = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R3", "mid-routine upc", int'(upc), 6);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mid-routine reset upc", int'(upc), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2", "after reset step", int'(upc), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule